// File: doc/BRIEF.md
# Byte-Burn Sequencer for a Clock-Addressed One-Time PROM

This controller sits on the programmer side of a one-time programmable memory whose address is not presented on pins. The address is an internal counter that is cleared by a mode pattern and advanced by bursts of four clock pulses. After a start command, the sequencer burns every byte from address zero up to a given last address. It drives the four mode lines, the address clock and the 8-bit data bus, and it reads the byte back through the same bus.

For each address the sequencer fetches the byte from a data source port. It then applies 1 ms write pulses, each followed by a verify read, until the read-back matches. A confirming write follows, lasting as many milliseconds as attempts were used. A byte that still fails after the attempt limit stops the run and reports its address. Every interval is derived from the clock-frequency parameter.

Top module: `prom_burn_seq`

## Requirements
- R1: Out of reset, and whenever idle, `mode` shows the clear pattern. `mode[0]` is the first mode line. The patterns are clear = 4'b0101, write = 4'b1110, verify = 4'b1100 and inhibit = 4'b1101. In the same state `prg_clk`, `bus_oe`, `busy`, `done` and `fail` are 0 and `bus_out` is 8'h00.
- R2: A `start` seen while idle captures `last_addr` and sets the working address to 0. Clear mode is then held for SETUP cycles, followed by inhibit for SETUP cycles.
- R3: Each write attempt has four parts. First comes inhibit with the byte driven for SETUP cycles. Then comes write mode for one pulse. Then comes inhibit with the byte still driven for SETUP cycles. Write mode is only ever entered from inhibit.
- R4: After the bus is released, verify mode lasts SETTLE_CYC cycles. `bus_in` is compared on the last of these cycles, and a mismatch starts another attempt.
- R5: On a match, the byte is driven in inhibit for SETUP cycles. Write mode then lasts N pulses, where N is the number of attempts used. Inhibit with the byte driven follows for SETUP cycles.
- R6: `bus_oe` is high only in the driven phases of R3 and R5, and `bus_out` is 8'h00 whenever `bus_oe` is low. Before every verify, the bus is released in inhibit for SETUP cycles.
- R7: Between two addresses, inhibit is held while `prg_clk` gives four pulses. Each pulse is high for CLK_PHASE_CYC cycles and then low for CLK_PHASE_CYC cycles. `src_addr` then rises by one, and a one-cycle inhibit load step takes `src_data`.
- R8: After the confirming write of the last address, no clock pulses are issued. Clear mode is held for SETUP cycles, after which the block goes idle with `done` = 1.
- R9: If the attempt that uses up MAX_TRIES fails to verify, the run stops and the block goes idle with `fail` = 1 and `fail_addr` set to that address. A byte that matches on exactly MAX_TRIES attempts succeeds.
- R10: A `start` asserted while `busy` is high has no effect.
- R11: One pulse lasts CLK_HZ/1000 cycles. SETUP is the number of cycles covering 2 µs, rounded up, with a minimum of 1.
- R12: `done` and `fail` hold their value while idle, are never high together, and are cleared by the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| last_addr | input | ADDR_W | Highest address to burn |
| src_addr | output | ADDR_W | Address whose byte is requested |
| src_data | input | 8 | Byte for `src_addr` |
| mode | output | 4 | Mode line pattern, bit 0 is the first line |
| prg_clk | output | 1 | Address advance clock |
| bus_out | output | 8 | Data driven toward the memory |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| bus_in | input | 8 | Data read back from the memory |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |
| fail | output | 1 | Last run stopped on a byte that would not verify |
| fail_addr | output | ADDR_W | Address of that byte |

## Verification
The bench builds the block with CLK_HZ = 1 MHz, so a pulse is 1000 cycles and SETUP is 2 cycles. It also sets MAX_TRIES = 4, SETTLE_CYC = 3, CLK_PHASE_CYC = 2 and ADDR_W = 4. These values keep multi-attempt bytes, the confirming write of up to four pulses, and a byte needing more than the attempt limit all within a short run. They also keep the rounded setup interval above one cycle. A behavioural memory model counts address clocks and write entries, and answers a verify with the right byte only after a chosen number of attempts. Each expected waveform is built from these counts and compared on every clock.

// File: rtl/prom_burn_seq.sv
module prom_burn_seq #(
  parameter int CLK_HZ        = 50_000_000,
  parameter int ADDR_W        = 14,
  parameter int MAX_TRIES     = 25,
  parameter int SETTLE_CYC    = 4,
  parameter int CLK_PHASE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] last_addr,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [7:0]        src_data,
  output logic [3:0]        mode,
  output logic              prg_clk,
  output logic [7:0]        bus_out,
  output logic              bus_oe,
  input  logic [7:0]        bus_in,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int PULSE_CYC = CLK_HZ / 1000;
  localparam int SETUP_RAW = (CLK_HZ / 1000 * 2 + 999) / 1000;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int T1   = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int T2   = (T1 > SETTLE_CYC) ? T1 : SETTLE_CYC;
  localparam int TMAX = (T2 > CLK_PHASE_CYC) ? T2 : CLK_PHASE_CYC;
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);

  localparam logic [3:0] M_CLEAR  = 4'b0101;
  localparam logic [3:0] M_WRITE  = 4'b1110;
  localparam logic [3:0] M_VERIFY = 4'b1100;
  localparam logic [3:0] M_INHIB  = 4'b1101;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_INH, S_LOAD, S_DSET, S_WR, S_WHOLD, S_REL,
    S_VER, S_XSET, S_XWR, S_XHOLD, S_STEP, S_END
  } st_t;

  st_t               st;
  logic [TMR_W-1:0]  tmr;
  logic [TRY_W-1:0]  tries, rep;
  logic [2:0]        ph;
  logic [ADDR_W-1:0] addr, last;
  logic [7:0]        data;

  function automatic logic [TMR_W-1:0] span(input st_t s);
    case (s)
      S_WR, S_XWR:     span = TMR_W'(PULSE_CYC - 1);
      S_VER:           span = TMR_W'(SETTLE_CYC - 1);
      S_STEP:          span = TMR_W'(CLK_PHASE_CYC - 1);
      S_LOAD, S_IDLE:  span = '0;
      default:         span = TMR_W'(SETUP_CYC - 1);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; tries <= '0; rep <= '0; ph <= '0;
      addr <= '0; last <= '0; data <= '0;
      done <= 1'b0; fail <= 1'b0; fail_addr <= '0;
    end else if (st == S_IDLE) begin
      if (start) begin
        st <= S_CLR; tmr <= span(S_CLR);
        addr <= '0; last <= last_addr;
        done <= 1'b0; fail <= 1'b0;
      end
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end else begin
      case (st)
        S_CLR:   begin st <= S_INH;  tmr <= span(S_INH);  end
        S_INH:   begin st <= S_LOAD; tmr <= span(S_LOAD); end
        S_LOAD:  begin data <= src_data; tries <= '0; st <= S_DSET; tmr <= span(S_DSET); end
        S_DSET:  begin tries <= tries + 1'b1; st <= S_WR; tmr <= span(S_WR); end
        S_WR:    begin st <= S_WHOLD; tmr <= span(S_WHOLD); end
        S_WHOLD: begin st <= S_REL;   tmr <= span(S_REL);   end
        S_REL:   begin st <= S_VER;   tmr <= span(S_VER);   end
        S_VER: begin
          if (bus_in == data) begin
            rep <= tries; st <= S_XSET; tmr <= span(S_XSET);
          end else if (tries == TRY_W'(MAX_TRIES)) begin
            st <= S_IDLE; fail <= 1'b1; fail_addr <= addr;
          end else begin
            st <= S_DSET; tmr <= span(S_DSET);
          end
        end
        S_XSET:  begin st <= S_XWR; tmr <= span(S_XWR); end
        S_XWR: begin
          if (rep == TRY_W'(1)) begin st <= S_XHOLD; tmr <= span(S_XHOLD); end
          else begin rep <= rep - 1'b1; tmr <= span(S_XWR); end
        end
        S_XHOLD: begin
          if (addr == last) begin st <= S_END; tmr <= span(S_END); end
          else begin ph <= '0; st <= S_STEP; tmr <= span(S_STEP); end
        end
        S_STEP: begin
          if (ph == 3'd7) begin addr <= addr + 1'b1; st <= S_LOAD; tmr <= span(S_LOAD); end
          else begin ph <= ph + 1'b1; tmr <= span(S_STEP); end
        end
        S_END:   begin st <= S_IDLE; done <= 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mode = (st == S_IDLE || st == S_CLR || st == S_END) ? M_CLEAR :
                (st == S_WR || st == S_XWR) ? M_WRITE :
                (st == S_VER) ? M_VERIFY : M_INHIB;
  assign bus_oe   = (st == S_DSET) || (st == S_WR) || (st == S_WHOLD) ||
                    (st == S_XSET) || (st == S_XWR) || (st == S_XHOLD);
  assign bus_out  = bus_oe ? data : 8'h00;
  assign prg_clk  = (st == S_STEP) && !ph[0];
  assign src_addr = addr;
  assign busy     = (st != S_IDLE);

  int wr_len;
  always_ff @(posedge clk) begin
    if (!rst_n) wr_len <= 0;
    else if (mode == M_WRITE) wr_len <= wr_len + 1;
    else wr_len <= 0;
  end

  AST_WRITE_WHOLE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_WRITE && mode != M_WRITE) |-> (wr_len != 0 && wr_len % PULSE_CYC == 0)); // R11
  AST_WRITE_FROM_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == M_WRITE) |-> $past(mode) == M_INHIB); // R3
  AST_BUS_FREE_BEFORE_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == M_VERIFY) |-> $past(!bus_oe)); // R6
  AST_CLOCK_IN_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    prg_clk |-> mode == M_INHIB); // R7
  AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TRY_W'(MAX_TRIES)); // R9
  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)); // R12
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && tmr != '0) |=> busy && $stable(src_addr)); // R10
endmodule

// File: tb/tb_prom_burn_seq.sv
module tb_prom_burn_seq;
  localparam int CLK_HZ = 1_000_000, AW = 4, MAXT = 4, SETTLE = 3, PH = 2;
  localparam int PULSE = 1000, SETUP = 2;
  localparam logic [3:0] M_CLR = 4'b0101, M_WR = 4'b1110, M_VER = 4'b1100, M_INH = 4'b1101;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] last_addr = '0, src_addr, fail_addr;
  logic [7:0] src_data, bus_out, bus_in;
  logic [3:0] mode;
  logic prg_clk, bus_oe, busy, done, fail;

  always #10 clk = ~clk;

  prom_burn_seq #(.CLK_HZ(CLK_HZ), .ADDR_W(AW), .MAX_TRIES(MAXT),
                  .SETTLE_CYC(SETTLE), .CLK_PHASE_CYC(PH)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .last_addr(last_addr),
    .src_addr(src_addr), .src_data(src_data), .mode(mode), .prg_clk(prg_clk),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .busy(busy),
    .done(done), .fail(fail), .fail_addr(fail_addr));

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + 5);
  endfunction
  assign src_data = pat(int'(src_addr));

  int need [16];
  int wcnt [16];
  int pclk_cnt = 0;
  logic [3:0] pmode_q = M_CLR;
  logic pclk_q = 0;
  int paddr;
  assign paddr = (pclk_cnt / 4) % 16;
  assign bus_in = (mode == M_VER) ? ((wcnt[paddr] >= need[paddr]) ? pat(paddr) : ~pat(paddr)) : 8'hFF;

  always @(negedge clk) begin
    pmode_q <= mode;
    pclk_q  <= prg_clk;
    if (mode == M_CLR) pclk_cnt <= 0;
    else if (prg_clk && !pclk_q) pclk_cnt <= pclk_cnt + 1;
    if (mode == M_WR && pmode_q != M_WR) wcnt[paddr] <= wcnt[paddr] + 1;
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  logic [3:0] em_q[$];
  logic ec_q[$], eo_q[$];
  logic [7:0] ed_q[$];
  logic [AW-1:0] ea_q[$];
  string et_q[$];

  task automatic seg(input logic [3:0] m, input logic c, input logic o, input logic [7:0] d,
                     input int a, input int n, input string t);
    for (int i = 0; i < n; i++) begin
      em_q.push_back(m); ec_q.push_back(c); eo_q.push_back(o);
      ed_q.push_back(d); ea_q.push_back(AW'(a)); et_q.push_back(t);
    end
  endtask

  task automatic build(input int last, output int fa);
    fa = -1;
    seg(M_CLR, 0, 0, 8'h00, 0, SETUP, "R2");
    seg(M_INH, 0, 0, 8'h00, 0, SETUP, "R2");
    for (int a = 0; a <= last; a++) begin
      logic [7:0] d;
      int k;
      d = pat(a);
      k = (need[a] > MAXT) ? MAXT : need[a];
      seg(M_INH, 0, 0, 8'h00, a, 1, "R7");
      for (int t = 0; t < k; t++) begin
        seg(M_INH, 0, 1, d, a, SETUP, "R3");
        seg(M_WR, 0, 1, d, a, PULSE, "R11");
        seg(M_INH, 0, 1, d, a, SETUP, "R3");
        seg(M_INH, 0, 0, 8'h00, a, SETUP, "R6");
        seg(M_VER, 0, 0, 8'h00, a, SETTLE, "R4");
      end
      if (need[a] > MAXT) begin fa = a; return; end
      seg(M_INH, 0, 1, d, a, SETUP, "R5");
      seg(M_WR, 0, 1, d, a, k * PULSE, "R5");
      seg(M_INH, 0, 1, d, a, SETUP, "R5");
      if (a != last)
        for (int p = 0; p < 8; p++) seg(M_INH, (p % 2) == 0, 0, 8'h00, a, PH, "R7");
    end
    seg(M_CLR, 0, 0, 8'h00, last, SETUP, "R8");
  endtask

  task automatic run(input int last, input bit poke);
    int fa, n, err0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) wcnt[i] = 0;
    em_q.delete(); ec_q.delete(); eo_q.delete(); ed_q.delete(); ea_q.delete(); et_q.delete();
    build(last, fa);
    last_addr = AW'(last);
    start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    err0 = errors;
    while (em_q.size() > 0) begin
      logic [31:0] act, exp;
      act = {11'd0, mode, prg_clk, bus_oe, bus_out, src_addr, busy, done, fail};
      exp = {11'd0, em_q[0], ec_q[0], eo_q[0], ed_q[0], ea_q[0], 1'b1, 1'b0, 1'b0};
      check(act == exp, et_q[0], act, exp);
      void'(em_q.pop_front()); void'(ec_q.pop_front()); void'(eo_q.pop_front());
      void'(ed_q.pop_front()); void'(ea_q.pop_front()); void'(et_q.pop_front());
      n++;
      if (poke) begin
        start = (n == 2 * SETUP + 10) || (n == 2 * SETUP + 500);
        if (n == 2 * SETUP + 500) last_addr = AW'(3);
      end
      @(negedge clk);
    end
    start = 0;
    if (poke) check(errors == err0, "R10 start while busy", 32'(errors), 32'(err0));
    if (fa < 0) begin
      check(done && !fail && !busy, "R8 done after last address", {29'd0, busy, done, fail}, 32'b010);
    end else begin
      check(fail && !done && !busy, "R9 fail flag", {29'd0, busy, done, fail}, 32'b001);
      check(fail_addr == AW'(fa), "R9 fail address", 32'(fail_addr), 32'(fa));
    end
    check(mode == M_CLR && !bus_oe && !prg_clk, "R1 idle outputs", {27'd0, mode, bus_oe}, {27'd0, M_CLR, 1'b0});
    repeat (5) @(negedge clk);
    check(done == (fa < 0) && fail == (fa >= 0), "R12 flags held while idle",
          {30'd0, done, fail}, {30'd0, fa < 0, fa >= 0});
  endtask

  initial begin
    for (int i = 0; i < 16; i++) need[i] = 1;
    repeat (3) @(negedge clk);
    check(mode == M_CLR && !prg_clk && !bus_oe && bus_out == 8'h00 && !busy && !done && !fail,
          "R1 reset state", {20'd0, mode, bus_out}, {20'd0, M_CLR, 8'h00});
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!busy && mode == M_CLR, "R1 idle after reset", {27'd0, mode, busy}, {27'd0, M_CLR, 1'b0});

    // R4 R5 R7: several attempt counts over four addresses
    need[0] = 1; need[1] = 3; need[2] = 2; need[3] = 1;
    run(3, 0);
    // R9 boundary: exactly MAX_TRIES attempts succeeds; R10 start while busy
    need[0] = MAXT;
    run(0, 1);
    // R9: a byte that never verifies within the limit
    need[0] = 2; need[1] = MAXT + 1; need[2] = 1;
    run(2, 0);
    // R12: a new run clears the fail flag
    need[0] = 1; need[1] = 2;
    run(1, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150_000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule